// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a 16-bit voltage-output converter. A host writes 24-bit commands over a three-wire serial port: an active-low frame-sync line, a serial clock and a data line. All three lines are brought into the system clock domain and edge-detected there. Bits are captured on falling serial-clock edges, most significant bit first. The system clock has to run at least four times faster than the serial clock.

A frame holds a 16-bit two's-complement sample and a 2-bit power-down selector. On the 24th falling edge the block commits the frame. It converts the stored sample to an offset-binary tap index for the resistor string, and it drives the amplifier enable and the output termination switches from the selected mode. A frame-sync rise before the 24th edge abandons the frame and leaves all state untouched. A power-down command changes the mode only, so the previous sample is still held when normal operation resumes.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, `dac_code_o` is 0x8000, `pd_mode_o` is 00, `amp_en_o` is 1, `term_sel_o` is 00, and neither strobe is set. These values hold until a frame commits.
- R2: A frame starts only on a high-to-low change of `sync_n_i`. Bits are sampled on falling edges of `sclk_i`, first bit first. The frame commits on the 24th falling edge, and `update_stb_o` pulses for one cycle as the outputs change.
- R3: The last 16 bits of a frame are the sample, first bit D15. `dac_code_o` equals the stored sample with bit 15 inverted.
- R4: Bits 7 and 8 of a frame (counting from 1) select the mode, and `pd_mode_o` shows them. For 00, `amp_en_o`=1 and `term_sel_o`=00. For 01, `amp_en_o`=0 and `term_sel_o`=01 (low-value resistor). For 10, `amp_en_o`=0 and `term_sel_o`=10 (high-value resistor). For 11, `amp_en_o`=0 and `term_sel_o`=00 (floating).
- R5: A frame whose mode is not 00 leaves the stored sample unchanged, and `dac_code_o` keeps its value.
- R6: If `sync_n_i` rises before the 24th falling edge, `abort_stb_o` pulses once. The stored sample and the mode do not change.
- R7: After the 24th edge, further falling clock edges while sync stays low neither shift data nor commit a frame.
- R8: The first six bits of a frame have no effect on any output.
- R9: If `sync_n_i` is already low when reset is released, clock edges commit nothing until sync has gone high and then low again.
- R10: A rise of `sync_n_i` after a frame has committed does not pulse `abort_stb_o` and does not undo the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Asynchronous active-low frame sync |
| sclk_i | input | 1 | Asynchronous serial clock |
| sdin_i | input | 1 | Asynchronous serial data |
| dac_code_o | output | 16 | Offset-binary tap index for the string |
| pd_mode_o | output | 2 | Current power-down mode |
| amp_en_o | output | 1 | Output amplifier enable |
| term_sel_o | output | 2 | Termination switches: bit 0 low-value resistor, bit 1 high-value resistor |
| update_stb_o | output | 1 | One-cycle pulse when a frame commits |
| abort_stb_o | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The hardest cases to reach are the ones where edges arrive at the wrong point in the frame. These are a sync rise after exactly 23 bits, extra clock edges after the 24th while sync stays low, and sync already low when reset is released. The bench drives the serial lines directly from a task that takes a bit count and a flag for releasing sync, so each of these cases is an ordinary call. Around each call it tracks how many update and abort pulses occur, and it checks that the expected model state has stayed in place. A sweep of sample values, including both ends of the range and the midpoint, covers the code conversion arithmetically.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;
    localparam int FRAME_BITS   = 24;
    localparam int SAMPLE_BITS  = 16;
    localparam int MODE_BITS    = 2;
    localparam int PAYLOAD_BITS = SAMPLE_BITS + MODE_BITS;

    typedef enum logic [MODE_BITS-1:0] {
        PM_ACTIVE    = 2'b00,
        PM_LOAD_LOW  = 2'b01,
        PM_LOAD_HIGH = 2'b10,
        PM_FLOAT     = 2'b11
    } pmode_t;

    typedef struct packed {
        pmode_t                 mode;
        logic [SAMPLE_BITS-1:0] sample;
    } payload_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_SHIFT = 2'b01,
        RX_HOLD  = 2'b10
    } rx_state_t;

    function automatic logic [SAMPLE_BITS-1:0] to_tap(input logic [SAMPLE_BITS-1:0] s);
        return {~s[SAMPLE_BITS-1], s[SAMPLE_BITS-2:0]};
    endfunction

    function automatic logic [1:0] term_of(input pmode_t m);
        case (m)
            PM_LOAD_LOW:  return 2'b01;
            PM_LOAD_HIGH: return 2'b10;
            default:      return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= raw_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_o <= '0;
        else     prev_o <= pipe[STAGES-1];
    end

    assign lvl_o = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_lvl_i,
    input  logic     sync_fall_i,
    input  logic     sclk_fall_i,
    input  logic     din_i,
    output logic     done_o,
    output logic     abort_o,
    output payload_t word_o
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    rx_state_t               state_q;
    logic [CW-1:0]           cnt_q;
    logic [PAYLOAD_BITS-2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            done_o  <= 1'b0;
            abort_o <= 1'b0;
            word_o  <= '0;
        end else begin
            done_o  <= 1'b0;
            abort_o <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (sync_fall_i) begin
                        state_q <= RX_SHIFT;
                        cnt_q   <= '0;
                        sh_q    <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (sync_lvl_i) begin
                        abort_o <= 1'b1;
                        state_q <= RX_IDLE;
                        cnt_q   <= '0;
                        sh_q    <= '0;
                    end else if (sclk_fall_i) begin
                        if (cnt_q == LAST) begin
                            done_o  <= 1'b1;
                            word_o  <= payload_t'({sh_q, din_i});
                            state_q <= RX_HOLD;
                            cnt_q   <= '0;
                            sh_q    <= '0;
                        end else begin
                            sh_q  <= {sh_q[PAYLOAD_BITS-3:0], din_i};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (sync_lvl_i) state_q <= RX_IDLE;
                end
            endcase
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && abort_o));
    a_r2_done_after_fall: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(sclk_fall_i));
    a_r7_hold_no_commit: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_HOLD) |=> !done_o);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_rx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  payload_t               word_i,
    output logic [SAMPLE_BITS-1:0] data_o,
    output pmode_t                 mode_o,
    output logic                   stb_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            mode_o <= PM_ACTIVE;
            stb_o  <= 1'b0;
        end else begin
            stb_o <= load_i;
            if (load_i) begin
                mode_o <= word_i.mode;
                if (word_i.mode == PM_ACTIVE) data_o <= word_i.sample;
            end
        end
    end

    a_r1_reset_midscale: assert property (@(posedge clk)
        rst |=> (data_o == '0 && mode_o == PM_ACTIVE));
    a_r5_pd_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_i.mode != PM_ACTIVE) |=> $stable(data_o));
    a_r6_no_load_stable: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(data_o) && $stable(mode_o)));
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
    import sdac_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_n_i,
    input  logic        sclk_i,
    input  logic        sdin_i,
    output logic [15:0] dac_code_o,
    output logic [1:0]  pd_mode_o,
    output logic        amp_en_o,
    output logic [1:0]  term_sel_o,
    output logic        update_stb_o,
    output logic        abort_stb_o
);
    logic [2:0] lvl, prev;
    logic       sync_fall, sclk_fall, done, abort;
    payload_t   word;
    logic [SAMPLE_BITS-1:0] data;
    pmode_t     mode;

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .raw_i({sync_n_i, sclk_i, sdin_i}),
        .lvl_o(lvl), .prev_o(prev)
    );

    assign sync_fall = prev[2] & ~lvl[2];
    assign sclk_fall = prev[1] & ~lvl[1];

    sdac_shifter u_shift (
        .clk(clk), .rst(rst),
        .sync_lvl_i(lvl[2]), .sync_fall_i(sync_fall),
        .sclk_fall_i(sclk_fall), .din_i(lvl[0]),
        .done_o(done), .abort_o(abort), .word_o(word)
    );

    sdac_regs u_regs (
        .clk(clk), .rst(rst), .load_i(done), .word_i(word),
        .data_o(data), .mode_o(mode), .stb_o(update_stb_o)
    );

    assign dac_code_o  = to_tap(data);
    assign pd_mode_o   = mode;
    assign amp_en_o    = (mode == PM_ACTIVE);
    assign term_sel_o  = term_of(mode);
    assign abort_stb_o = abort;

    a_r4_term_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(term_sel_o));
    a_r4_amp_off_when_terminated: assert property (@(posedge clk) disable iff (rst)
        (term_sel_o != 2'b00) |-> !amp_en_o);
endmodule

// File: tb/sdac_cmd_rx_bench.sv
module sdac_cmd_rx_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic [15:0] dac_code;
    logic [1:0]  pd_mode, term_sel;
    logic        amp_en, upd, abt;

    int checks = 0, errors = 0;
    int upd_cnt = 0, abt_cnt = 0;
    logic [15:0] exp_data = 16'h0000;
    logic [1:0]  exp_mode = 2'b00;

    always #5 clk = ~clk;

    sdac_cmd_rx u_sdac_cmd_rx (
        .clk(clk), .rst(rst), .sync_n_i(sync_n), .sclk_i(sclk), .sdin_i(sdin),
        .dac_code_o(dac_code), .pd_mode_o(pd_mode), .amp_en_o(amp_en),
        .term_sel_o(term_sel), .update_stb_o(upd), .abort_stb_o(abt)
    );

    always @(posedge clk) begin
        if (upd) upd_cnt <= upd_cnt + 1;
        if (abt) abt_cnt <= abt_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drives bits w[n-1] down to w[0]; releases sync when rel is set
    task automatic send(input logic [31:0] w, input int n, input bit rel);
        sync_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < n; i++) begin
            sdin = w[n-1-i];
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(4);
        end
        if (rel) begin
            sync_n = 1'b1;
            wait_cyc(12);
        end
    endtask

    function automatic logic [23:0] mk(input logic [5:0] pad, input logic [1:0] m,
                                       input logic [15:0] d);
        return {pad, m, d};
    endfunction

    task automatic check_outputs(input string req);
        chk({req, " code"}, dac_code, exp_data ^ 16'h8000);
        chk({req, " mode"}, pd_mode, exp_mode);
        chk({req, " amp"}, amp_en, exp_mode == 2'b00);
        chk({req, " term"}, term_sel,
            exp_mode == 2'b01 ? 2'b01 : (exp_mode == 2'b10 ? 2'b10 : 2'b00));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int u0, a0;
        logic [15:0] d;
        // R9: sync already low at reset release
        sync_n = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        // R1: reset state
        check_outputs("R1");
        chk("R1 strobes", {upd, abt}, 2'b00);
        u0 = upd_cnt;
        for (int i = 0; i < 24; i++) begin
            sdin = 1'b1; sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
        end
        wait_cyc(10);
        chk("R9 no update", upd_cnt - u0, 0);
        check_outputs("R9");
        sync_n = 1'b1;
        wait_cyc(10);

        // R2/R3: sweep of samples, normal mode
        for (int i = 0; i < 40; i++) begin
            case (i)
                0: d = 16'h0000;
                1: d = 16'h7FFF;
                2: d = 16'h8000;
                3: d = 16'hFFFF;
                default: d = 16'(i * 1637 + 91);
            endcase
            u0 = upd_cnt;
            send({8'h00, mk(6'h00, 2'b00, d)}, 24, 1'b1);
            exp_data = d; exp_mode = 2'b00;
            chk("R2 one update", upd_cnt - u0, 1);
            check_outputs("R3");
        end

        // R8: pad bits set to ones
        send({8'h00, mk(6'h3F, 2'b00, 16'h1234)}, 24, 1'b1);
        exp_data = 16'h1234;
        check_outputs("R8");

        // R4/R5: each power-down mode, sample must stay
        for (int m = 1; m < 4; m++) begin
            send({8'h00, mk(6'h00, 2'(m), 16'hABCD)}, 24, 1'b1);
            exp_mode = 2'(m);
            check_outputs("R4 R5");
        end
        send({8'h00, mk(6'h00, 2'b00, 16'h4321)}, 24, 1'b1);
        exp_data = 16'h4321; exp_mode = 2'b00;
        check_outputs("R4 back to normal");

        // R6: abort after 23 bits
        u0 = upd_cnt; a0 = abt_cnt;
        send({8'h00, mk(6'h00, 2'b11, 16'h0F0F)}, 23, 1'b1);
        chk("R6 abort pulse", abt_cnt - a0, 1);
        chk("R6 no update", upd_cnt - u0, 0);
        check_outputs("R6");

        // R6: abort after 3 bits, then a clean frame still works
        a0 = abt_cnt;
        send(32'h7, 3, 1'b1);
        chk("R6 short abort", abt_cnt - a0, 1);
        send({8'h00, mk(6'h00, 2'b00, 16'h0001)}, 24, 1'b1);
        exp_data = 16'h0001;
        check_outputs("R6 recover");

        // R7/R10: 8 extra edges after the 24th, sync still low
        u0 = upd_cnt; a0 = abt_cnt;
        send({mk(6'h00, 2'b00, 16'hC3A5), 8'hFF}, 32, 1'b0);
        wait_cyc(10);
        exp_data = 16'hC3A5;
        chk("R7 single update", upd_cnt - u0, 1);
        check_outputs("R7");
        sync_n = 1'b1;
        wait_cyc(12);
        chk("R10 no abort", abt_cnt - a0, 0);
        check_outputs("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule